// File: doc/BRIEF.md
# Selectable-Order PRBS Link Checker

This block checks a bit stream received on one of several input lanes against a pseudo-random binary sequence. The host chooses the sequence order, the lane, and a run length given as a number of fixed-size blocks (10000 bits each by default). One bit arrives per cycle in which the valid strobe is high.

A run starts with a start pulse. The checker first loads its reference generator from the first received bits. It then predicts every following bit on its own and compares each prediction with the received bit. It keeps two results. One is the total number of mismatched bits. The other is the number of error bursts, where each burst is counted once on a change from a matching bit to a mismatching bit. Both counters hold at full scale, and both stay readable after the run ends. A done flag shows that the whole requested length has been compared.

Top module: `prbs_link_checker`

## Requirements
- R1: After reset the block is idle. busy and done are 0, both error counters read 0, and the lane readback reads 0.
- R2: order_cfg selects the sequence as follows. 1 gives x^7+x^6+1, 2 gives x^15+x^14+1, 3 gives x^23+x^18+1 and 4 gives x^31+x^28+1. Each received bit b[n] is expected to equal b[n-L] xor b[n-T], where L is the degree and T the middle term. The order is captured on the start pulse, so later changes to order_cfg have no effect on a run in progress.
- R3: After a start, the first L valid bits (L is the polynomial degree) load the reference generator and are never counted as errors.
- R4: After seeding, exactly blocks_cfg × BLOCK_BITS valid bits are compared. done rises in the clock cycle that compares the last bit, and busy falls in that same cycle. done then stays high until the next accepted start. Cycles in which bit_vld is low are ignored.
- R5: bit_errs counts the compared bits whose received value differs from the prediction. The reference keeps running on its own predictions, so a single flipped bit adds exactly one error.
- R6: edge_errs counts the compared bits that mismatch while the previous compared bit matched. A mismatch on the first compared bit counts as an edge.
- R7: Both counters stop at 2^CNT_W−1 and do not wrap.
- R8: An accepted start clears both counters and done, and begins a new seeding phase. This holds even while a run is in progress.
- R9: A start is ignored when order_cfg is outside 1..4 or blocks_cfg is 0. In that case done and the counters keep their values.
- R10: Pulsing sel_wr loads sel_wdata into the lane select, and sel_rd reads it back. A value of NLANES or more is ignored.
- R11: Only the selected lane of lane_bits is checked. The data on every other lane has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| order_cfg | input | 3 | Sequence order code (1..4) |
| blocks_cfg | input | BLK_W | Run length in blocks of BLOCK_BITS |
| start | input | 1 | Start a run (one-cycle pulse) |
| sel_wr | input | 1 | Write strobe for the lane select |
| sel_wdata | input | $clog2(NLANES) | New lane select value |
| sel_rd | output | $clog2(NLANES) | Current lane select |
| lane_bits | input | NLANES | One received bit per lane |
| bit_vld | input | 1 | lane_bits carries a new bit this cycle |
| busy | output | 1 | Seeding or comparing |
| done | output | 1 | The full length has been compared |
| bit_errs | output | CNT_W | Saturating count of mismatched bits |
| edge_errs | output | CNT_W | Saturating count of error bursts |

## Verification
Two events can happen in the same cycle. The error logic can register a mismatch in the very cycle that compares the last bit and raises done. The bench provokes this by flipping the final compared bit of a run, and it also flips the first compared bit. It then checks that both counters include that final bit and that done is high after that one cycle. A second case is a restart that arrives while a run with errors is still in progress. The bench checks that the clear wins and that the new clean run reports zero.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    localparam int SR_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEED,
        ST_CHECK,
        ST_DONE
    } chk_state_e;

    typedef enum logic [2:0] {
        ORD_OFF = 3'd0,
        ORD_P7  = 3'd1,
        ORD_P15 = 3'd2,
        ORD_P23 = 3'd3,
        ORD_P31 = 3'd4
    } prbs_order_e;

    typedef struct packed {
        logic [4:0] len;
        logic [4:0] tap;
    } poly_t;

    function automatic logic order_valid(input logic [2:0] code);
        return (code >= 3'd1) && (code <= 3'd4);
    endfunction

    function automatic poly_t poly_of(input logic [2:0] code);
        poly_t p;
        case (prbs_order_e'(code))
            ORD_P15: begin p.len = 5'd15; p.tap = 5'd14; end
            ORD_P23: begin p.len = 5'd23; p.tap = 5'd18; end
            ORD_P31: begin p.len = 5'd31; p.tap = 5'd28; end
            default: begin p.len = 5'd7;  p.tap = 5'd6;  end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/prbs_lane_sel.sv
module prbs_lane_sel #(
    parameter int NLANES = 7
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr,
    input  logic [$clog2(NLANES)-1:0] wdata,
    output logic [$clog2(NLANES)-1:0] sel_q,
    input  logic [NLANES-1:0]         lanes,
    output logic                      bit_out
);
    localparam int SW = $clog2(NLANES);

    logic [NLANES-1:0] hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr && ({1'b0, wdata} < (SW+1)'(NLANES))) begin
            sel_q <= wdata;
        end
    end

    for (genvar i = 0; i < NLANES; i++) begin : g_pick
        assign hit[i] = lanes[i] & (sel_q == SW'(i));
    end

    assign bit_out = |hit;

endmodule

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen
    import prbs_chk_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  seed_en,
    input  logic  step_en,
    input  logic  rx_bit,
    input  poly_t poly,
    output logic  pred
);
    logic [SR_W-1:0] sr;
    logic [4:0]      len_idx;
    logic [4:0]      tap_idx;

    assign len_idx = poly.len - 5'd1;
    assign tap_idx = poly.tap - 5'd1;
    assign pred    = sr[len_idx] ^ sr[tap_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (seed_en) begin
            sr <= {sr[SR_W-2:0], rx_bit};
        end else if (step_en) begin
            sr <= {sr[SR_W-2:0], pred};
        end
    end

endmodule

// File: rtl/prbs_sat_cnt.sv
module prbs_sat_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (inc && (cnt != {W{1'b1}})) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/prbs_link_checker.sv
module prbs_link_checker
    import prbs_chk_pkg::*;
#(
    parameter int NLANES     = 7,
    parameter int BLOCK_BITS = 10000,
    parameter int CNT_W      = 16,
    parameter int BLK_W      = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [2:0]                order_cfg,
    input  logic [BLK_W-1:0]          blocks_cfg,
    input  logic                      start,
    input  logic                      sel_wr,
    input  logic [$clog2(NLANES)-1:0] sel_wdata,
    output logic [$clog2(NLANES)-1:0] sel_rd,
    input  logic [NLANES-1:0]         lane_bits,
    input  logic                      bit_vld,
    output logic                      busy,
    output logic                      done,
    output logic [CNT_W-1:0]          bit_errs,
    output logic [CNT_W-1:0]          edge_errs
);
    localparam int BIT_W = $clog2(BLOCK_BITS);

    chk_state_e       state;
    poly_t            poly_q;
    logic [BLK_W-1:0] blk_lim;
    logic [BLK_W-1:0] blk_cnt;
    logic [BIT_W-1:0] bit_cnt;
    logic [4:0]       seed_cnt;
    logic             prev_mis;
    logic             rx_bit;
    logic             pred;
    logic             go;
    logic             seed_en;
    logic             step_en;
    logic             mis;
    logic             blk_last;
    logic             bit_last;

    prbs_lane_sel #(.NLANES(NLANES)) u_sel (
        .clk     (clk),
        .rst     (rst),
        .wr      (sel_wr),
        .wdata   (sel_wdata),
        .sel_q   (sel_rd),
        .lanes   (lane_bits),
        .bit_out (rx_bit)
    );

    assign go      = start && order_valid(order_cfg) && (blocks_cfg != '0);
    assign seed_en = !go && bit_vld && (state == ST_SEED);
    assign step_en = !go && bit_vld && (state == ST_CHECK);
    assign mis     = step_en && (pred != rx_bit);

    assign bit_last = (bit_cnt == BIT_W'(BLOCK_BITS - 1));
    assign blk_last = (blk_cnt == blk_lim - BLK_W'(1));

    prbs_ref_gen u_ref (
        .clk     (clk),
        .rst     (rst),
        .seed_en (seed_en),
        .step_en (step_en),
        .rx_bit  (rx_bit),
        .poly    (poly_q),
        .pred    (pred)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            poly_q   <= poly_of(3'd1);
            blk_lim  <= '0;
            blk_cnt  <= '0;
            bit_cnt  <= '0;
            seed_cnt <= '0;
            prev_mis <= 1'b0;
        end else if (go) begin
            state    <= ST_SEED;
            poly_q   <= poly_of(order_cfg);
            blk_lim  <= blocks_cfg;
            blk_cnt  <= '0;
            bit_cnt  <= '0;
            seed_cnt <= '0;
            prev_mis <= 1'b0;
        end else if (bit_vld) begin
            case (state)
                ST_SEED: begin
                    if (seed_cnt == poly_q.len - 5'd1) begin
                        state <= ST_CHECK;
                    end else begin
                        seed_cnt <= seed_cnt + 5'd1;
                    end
                end
                ST_CHECK: begin
                    prev_mis <= mis;
                    if (bit_last) begin
                        bit_cnt <= '0;
                        if (blk_last) begin
                            state <= ST_DONE;
                        end else begin
                            blk_cnt <= blk_cnt + BLK_W'(1);
                        end
                    end else begin
                        bit_cnt <= bit_cnt + BIT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    prbs_sat_cnt #(.W(CNT_W)) u_bits (
        .clk (clk),
        .rst (rst),
        .clr (go),
        .inc (mis),
        .cnt (bit_errs)
    );

    prbs_sat_cnt #(.W(CNT_W)) u_edges (
        .clk (clk),
        .rst (rst),
        .clr (go),
        .inc (mis && !prev_mis),
        .cnt (edge_errs)
    );

    assign busy = (state == ST_SEED) || (state == ST_CHECK);
    assign done = (state == ST_DONE);

endmodule

// File: rtl/prbs_link_checker_sva.sv
module prbs_link_checker_sva
    import prbs_chk_pkg::*;
#(
    parameter int NLANES = 7,
    parameter int CNT_W  = 16,
    parameter int BLK_W  = 16
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      start,
    input logic [2:0]                order_cfg,
    input logic [BLK_W-1:0]          blocks_cfg,
    input logic [$clog2(NLANES)-1:0] sel_rd,
    input logic                      busy,
    input logic                      done,
    input logic [CNT_W-1:0]          bit_errs,
    input logic [CNT_W-1:0]          edge_errs
);
    logic accepted;
    logic refused;

    assign accepted = start && order_valid(order_cfg) && (blocks_cfg != '0);
    assign refused  = start && !accepted;

    AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        accepted |=> (bit_errs == '0 && edge_errs == '0 && busy && !done)); // R8

    AST_REFUSED_START: assert property (@(posedge clk) disable iff (rst)
        (refused && !busy) |=> ($stable(done) && $stable(bit_errs) && $stable(edge_errs))); // R9

    AST_BITS_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (bit_errs == {CNT_W{1'b1}} && !accepted) |=> bit_errs == {CNT_W{1'b1}}); // R7

    AST_EDGES_BOUNDED: assert property (@(posedge clk) disable iff (rst)
        edge_errs <= bit_errs); // R6

    AST_DONE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(busy && done)); // R4

    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (done && !accepted) |=> done); // R4

    AST_LANE_RANGE: assert property (@(posedge clk) disable iff (rst)
        {1'b0, sel_rd} < ($clog2(NLANES)+1)'(NLANES)); // R10

endmodule

bind prbs_link_checker prbs_link_checker_sva #(
    .NLANES (NLANES),
    .CNT_W  (CNT_W),
    .BLK_W  (BLK_W)
) u_sva (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .order_cfg  (order_cfg),
    .blocks_cfg (blocks_cfg),
    .sel_rd     (sel_rd),
    .busy       (busy),
    .done       (done),
    .bit_errs   (bit_errs),
    .edge_errs  (edge_errs)
);

// File: tb/tb_prbs_link_checker.sv
module tb_prbs_link_checker;

    localparam int NLANES     = 7;
    localparam int BLOCK_BITS = 20;
    localparam int CNT_W      = 6;
    localparam int BLK_W      = 8;
    localparam int SW         = $clog2(NLANES);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        order_cfg = 3'd0;
    logic [BLK_W-1:0]  blocks_cfg = '0;
    logic              start = 1'b0;
    logic              sel_wr = 1'b0;
    logic [SW-1:0]     sel_wdata = '0;
    logic [SW-1:0]     sel_rd;
    logic [NLANES-1:0] lane_bits = '0;
    logic              bit_vld = 1'b0;
    logic              busy;
    logic              done;
    logic [CNT_W-1:0]  bit_errs;
    logic [CNT_W-1:0]  edge_errs;

    int n_checks = 0;
    int n_fail   = 0;
    bit flip [0:255];

    always #5 clk = ~clk;

    prbs_link_checker #(
        .NLANES(NLANES), .BLOCK_BITS(BLOCK_BITS), .CNT_W(CNT_W), .BLK_W(BLK_W)
    ) dut (
        .clk(clk), .rst(rst), .order_cfg(order_cfg), .blocks_cfg(blocks_cfg),
        .start(start), .sel_wr(sel_wr), .sel_wdata(sel_wdata), .sel_rd(sel_rd),
        .lane_bits(lane_bits), .bit_vld(bit_vld), .busy(busy), .done(done),
        .bit_errs(bit_errs), .edge_errs(edge_errs)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_flips();
        for (int i = 0; i < 256; i++) flip[i] = 1'b0;
    endtask

    task automatic write_sel(input int v);
        @(negedge clk);
        sel_wr = 1'b1;
        sel_wdata = SW'(v);
        @(negedge clk);
        sel_wr = 1'b0;
    endtask

    // Drives seed and compared bits; stops early after stop_after compared bits if >= 0.
    task automatic run_stream(input int ord, input int lane, input int nblk, input bit gaps,
                              input bit inv_chk, input int ord_after, input int stop_after);
        int len;
        int tap;
        int total;
        int last;
        bit b;
        bit h [0:255];
        case (ord)
            2: begin len = 15; tap = 14; end
            3: begin len = 23; tap = 18; end
            4: begin len = 31; tap = 28; end
            default: begin len = 7; tap = 6; end
        endcase
        total = nblk * BLOCK_BITS;
        for (int i = 0; i < len; i++) h[i] = ((i % 3) == 0) || (i == 1);
        for (int n = len; n < len + total; n++) h[n] = h[n - len] ^ h[n - tap];
        last = (stop_after >= 0) ? len + stop_after : len + total;
        @(negedge clk);
        order_cfg = 3'(ord);
        blocks_cfg = BLK_W'(nblk);
        start = 1'b1;
        bit_vld = 1'b0;
        @(negedge clk);
        start = 1'b0;
        order_cfg = 3'(ord_after);
        for (int k = 0; k < last; k++) begin
            if (gaps && (k % 3) == 2) begin
                for (int j = 0; j < NLANES; j++) lane_bits[j] = ~h[k];
                bit_vld = 1'b0;
                @(negedge clk);
            end
            b = h[k];
            if (k >= len && (inv_chk || flip[k - len])) b = ~b;
            if (stop_after < 0 && k == len + total - 1)
                check("R4 done low before last bit", int'(done), 0);
            for (int j = 0; j < NLANES; j++) lane_bits[j] = (j == lane) ? b : ~b;
            bit_vld = 1'b1;
            @(negedge clk);
        end
        bit_vld = 1'b0;
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        clear_flips();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 bit_errs", int'(bit_errs), 0);
        check("R1 edge_errs", int'(edge_errs), 0);
        check("R1 sel_rd", int'(sel_rd), 0);

        // R2 R3 R11: sweep orders and lanes, clean data, others lanes inverted
        for (int ord = 1; ord <= 4; ord++) begin
            for (int ln = 0; ln < NLANES; ln++) begin
                write_sel(ln);
                check("R10 sel readback", int'(sel_rd), ln);
                run_stream(ord, ln, 2, ln[0], 1'b0, ord, -1);
                check("R2 R3 R11 clean bit_errs", int'(bit_errs), 0);
                check("R11 clean edge_errs", int'(edge_errs), 0);
                check("R4 done after full length", int'(done), 1);
                check("R4 busy low at end", int'(busy), 0);
            end
        end

        // R10: out-of-range lane select ignored
        write_sel(3);
        write_sel(7);
        check("R10 out of range ignored", int'(sel_rd), 3);

        // R5 R6: flips at first, burst, and last compared bit (same cycle as done)
        clear_flips();
        flip[0] = 1'b1; flip[10] = 1'b1; flip[11] = 1'b1; flip[12] = 1'b1; flip[39] = 1'b1;
        run_stream(2, 3, 2, 1'b1, 1'b0, 2, -1);
        check("R5 bit_errs with last-bit flip", int'(bit_errs), 5);
        check("R6 edge_errs bursts", int'(edge_errs), 3);
        check("R4 done with last-bit error", int'(done), 1);

        // R9: refused starts keep results
        @(negedge clk); order_cfg = 3'd5; blocks_cfg = 8'd2; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check("R9 bad order done kept", int'(done), 1);
        check("R9 bad order bits kept", int'(bit_errs), 5);
        @(negedge clk); order_cfg = 3'd1; blocks_cfg = 8'd0; start = 1'b1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        check("R9 zero blocks edges kept", int'(edge_errs), 3);
        check("R9 zero blocks busy", int'(busy), 0);

        // R5: adjacent flips on highest order, lane 6
        write_sel(6);
        clear_flips();
        flip[5] = 1'b1; flip[6] = 1'b1;
        run_stream(4, 6, 1, 1'b0, 1'b0, 4, -1);
        check("R5 two flips", int'(bit_errs), 2);
        check("R6 one burst", int'(edge_errs), 1);
        clear_flips();

        // R7: every compared bit wrong, 80 > 63
        write_sel(0);
        run_stream(1, 0, 4, 1'b0, 1'b1, 1, -1);
        check("R7 bit_errs saturated", int'(bit_errs), 63);
        check("R6 R7 edge single burst", int'(edge_errs), 1);

        // R8: restart while busy clears and runs clean
        run_stream(3, 0, 2, 1'b0, 1'b1, 3, 5);
        check("R8 mid-run busy", int'(busy), 1);
        check("R8 mid-run bits", int'(bit_errs), 5);
        run_stream(3, 0, 2, 1'b0, 1'b0, 3, -1);
        check("R8 restart clean bits", int'(bit_errs), 0);
        check("R8 restart done", int'(done), 1);

        // R2: order captured at start; order_cfg changed during run
        run_stream(3, 0, 1, 1'b1, 1'b0, 1, -1);
        check("R2 order latched", int'(bit_errs), 0);
        check("R2 order latched done", int'(done), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule